// File: doc/BRIEF.md
# Keyed Flash Erase Command Controller

This block starts erase cycles on an on-chip flash array for a small microcontroller. Software reaches it through a byte-wide register port with a write strobe and a combinational read mux. Two registers arm an erase. A write to the page-number register arms one page erase. A write of any value to the mass-enable register arms one whole-array erase. An erase starts only when one of two exact key bytes is written to the command register and the matching arm is present.

An accepted command sends a one-cycle request to the flash array, with the page number held on its own lines, and raises busy. Busy stays high until the array returns a done pulse. Each accepted erase uses up its arm. Any key written while busy is dropped. Register writes made while busy are stored, and the arms they set count towards a later command.

The sequencer has five states. S_IDLE goes to S_PG_START on an accepted page key, or to S_MS_START on an accepted mass key. S_PG_START always goes to S_PG_WAIT, and S_MS_START always goes to S_MS_WAIT, each after one cycle. Both wait states go back to S_IDLE when done arrives.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset, the command register (address 0) and the page register (address 1) read 0x00, the status register (address 3) reads 0x00, busy is low and neither request is high.
- R2: In S_IDLE, writing 0x55 to address 0 while the page arm is set raises page_erase_req in the cycle after the write edge. At the same time busy rises and erase_page shows the stored page number.
- R3: In S_IDLE, writing 0xAA to address 0 while the mass arm is set and dbg_en is high raises mass_erase_req in the cycle after the write edge, and busy rises.
- R4: Writing any command byte other than 0x55 or 0xAA starts nothing and leaves both arms unchanged.
- R5: The page register stores bits 6:0 of the written byte and reads back with bit 7 as zero.
- R6: A 0x55 command with no page arm is ignored. An accepted page erase clears the page arm, so repeating 0x55 without a new page write is ignored.
- R7: A 0xAA command is ignored while the mass arm is clear or dbg_en is low. An accepted mass erase clears the mass arm.
- R8: While busy, every command write is ignored.
- R9: Each request lasts exactly one cycle. erase_page does not change from the request until done.
- R10: Writes to the page register or to the mass-enable register (address 2) made while busy are stored, and their arms allow the next command after done.
- R11: A read of the status register (address 3) returns busy in bit 0, the page arm in bit 1 and the mass arm in bit 2. All other bits read zero.
- R12: Busy falls in the cycle after the edge that samples erase_done in a wait state. A done pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 command, 1 page, 2 mass enable) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 command, 1 page, 3 status) |
| rd_data | output | 8 | Combinational read data |
| dbg_en | input | 1 | Debug-enable qualifier for mass erase |
| erase_done | input | 1 | Completion pulse from the flash array |
| page_erase_req | output | 1 | One-cycle page-erase request |
| mass_erase_req | output | 1 | One-cycle mass-erase request |
| erase_page | output | 7 | Page number for the current page erase |
| busy | output | 1 | Erase in progress |

## Verification
Every register update, and so every request and busy change, shows up in the cycle that follows the write edge. The status read path adds no delay, so a status read gives the new arms and busy as soon as that edge has passed. A request is high for that one cycle only, and busy falls one cycle after the edge that samples done. The bench drives inputs on falling edges and samples on the next falling edge. It checks the request and busy right after the write edge, the absence of the request one cycle later, and the fall of busy one cycle after done.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
    localparam logic [ADDR_W-1:0] A_PAGE = 2'd1;
    localparam logic [ADDR_W-1:0] A_MEN  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PG_START,
        S_PG_WAIT,
        S_MS_START,
        S_MS_WAIT
    } seq_state_t;
endpackage

// File: rtl/fe_regs.sv
module fe_regs
    import fe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_page_arm,
    input  logic              clr_mass_arm,
    output logic              cmd_wr,
    output logic [DATA_W-1:0] cmd_q,
    output logic [PAGE_W-1:0] page_q,
    output logic              page_arm,
    output logic              mass_arm
);
    logic page_wr, men_wr;

    assign cmd_wr  = wr_en && (wr_addr == A_CMD);
    assign page_wr = wr_en && (wr_addr == A_PAGE);
    assign men_wr  = wr_en && (wr_addr == A_MEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            page_q   <= '0;
            page_arm <= 1'b0;
            mass_arm <= 1'b0;
        end else begin
            if (cmd_wr) cmd_q <= wr_data;
            if (page_wr) begin
                page_q   <= wr_data[PAGE_W-1:0];
                page_arm <= 1'b1;
            end else if (clr_page_arm) begin
                page_arm <= 1'b0;
            end
            if (men_wr) mass_arm <= 1'b1;
            else if (clr_mass_arm) mass_arm <= 1'b0;
        end
    end

    // R6: an accepted page erase uses up its arm
    assert_page_arm_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_page_arm |=> !page_arm);
    // R7: an accepted mass erase uses up its arm
    assert_mass_arm_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mass_arm |=> !mass_arm);
    // R10: a page write always arms, whatever the sequencer is doing
    assert_page_write_arms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr |=> page_arm);
endmodule

// File: rtl/fe_seq.sv
module fe_seq
    import fe_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                PAGE_W   = 7,
    parameter logic [DATA_W-1:0] KEY_PAGE = 8'h55,
    parameter logic [DATA_W-1:0] KEY_MASS = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              page_arm,
    input  logic              mass_arm,
    input  logic              dbg_en,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              done,
    output logic              clr_page_arm,
    output logic              clr_mass_arm,
    output logic              page_req,
    output logic              mass_req,
    output logic              busy,
    output logic [PAGE_W-1:0] page_out
);
    seq_state_t state, state_nx;
    logic idle, go_page, go_mass;

    assign idle    = (state == S_IDLE);
    assign go_page = idle && cmd_wr && (cmd_data == KEY_PAGE) && page_arm;
    assign go_mass = idle && cmd_wr && (cmd_data == KEY_MASS) && mass_arm && dbg_en;
    assign clr_page_arm = go_page;
    assign clr_mass_arm = go_mass;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (go_page)      state_nx = S_PG_START;
                else if (go_mass) state_nx = S_MS_START;
            end
            S_PG_START: state_nx = S_PG_WAIT;
            S_PG_WAIT:  if (done) state_nx = S_IDLE;
            S_MS_START: state_nx = S_MS_WAIT;
            S_MS_WAIT:  if (done) state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            page_out <= '0;
        end else begin
            state <= state_nx;
            if (go_page) page_out <= page_in;
        end
    end

    always_comb begin
        page_req = 1'b0;
        mass_req = 1'b0;
        busy     = 1'b1;
        unique case (state)
            S_IDLE:     busy     = 1'b0;
            S_PG_START: page_req = 1'b1;
            S_PG_WAIT:  ;
            S_MS_START: mass_req = 1'b1;
            S_MS_WAIT:  ;
            default:    busy     = 1'b0;
        endcase
    end

    assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (page_req || mass_req) |=> !(page_req || mass_req));
    assert_page_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !idle && $past(busy)) |-> $stable(page_out));
    assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(clr_page_arm || clr_mass_arm));
    assert_req_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(page_req && mass_req));
    assert_mass_needs_dbg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mass_arm |-> dbg_en);
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
    import fe_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                PAGE_W   = 7,
    parameter logic [DATA_W-1:0] KEY_PAGE = 8'h55,
    parameter logic [DATA_W-1:0] KEY_MASS = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dbg_en,
    input  logic              erase_done,
    output logic              page_erase_req,
    output logic              mass_erase_req,
    output logic [PAGE_W-1:0] erase_page,
    output logic              busy
);
    localparam int PAD_PAGE = DATA_W - PAGE_W;
    localparam int PAD_STAT = DATA_W - 3;

    logic              cmd_wr, page_arm, mass_arm, clr_page_arm, clr_mass_arm;
    logic [DATA_W-1:0] cmd_q;
    logic [PAGE_W-1:0] page_q;

    fe_regs #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clr_page_arm(clr_page_arm),
        .clr_mass_arm(clr_mass_arm), .cmd_wr(cmd_wr), .cmd_q(cmd_q),
        .page_q(page_q), .page_arm(page_arm), .mass_arm(mass_arm)
    );

    fe_seq #(.DATA_W(DATA_W), .PAGE_W(PAGE_W),
             .KEY_PAGE(KEY_PAGE), .KEY_MASS(KEY_MASS)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(wr_data),
        .page_arm(page_arm), .mass_arm(mass_arm), .dbg_en(dbg_en),
        .page_in(page_q), .done(erase_done),
        .clr_page_arm(clr_page_arm), .clr_mass_arm(clr_mass_arm),
        .page_req(page_erase_req), .mass_req(mass_erase_req),
        .busy(busy), .page_out(erase_page)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CMD:   rd_data = cmd_q;
            A_PAGE:  rd_data = {{PAD_PAGE{1'b0}}, page_q};
            A_STAT:  rd_data = {{PAD_STAT{1'b0}}, mass_arm, page_arm, busy};
            default: rd_data = '0;
        endcase
    end

    assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (page_erase_req || mass_erase_req) |-> busy);
    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && erase_done && !wr_en) |=> !busy);
endmodule

// File: tb/sim_flash_erase_ctl.sv
module sim_flash_erase_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       dbg_en = 1'b0;
    logic       erase_done = 1'b0;
    logic       page_erase_req, mass_erase_req, busy;
    logic [6:0] erase_page;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_erase_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dbg_en(dbg_en), .erase_done(erase_done),
        .page_erase_req(page_erase_req), .mass_erase_req(mass_erase_req),
        .erase_page(erase_page), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); check("R1 cmd", v, 0);
        rd(2'd1, v); check("R1 page", v, 0);
        rd(2'd3, v); check("R1 status", v, 0);
        check("R1 reqs", {page_erase_req, mass_erase_req, busy}, 0);
    endtask

    task automatic t_page_flow();
        logic [7:0] v;
        wr(2'd1, 8'h85);
        rd(2'd1, v); check("R5 page readback", v, 8'h05);
        rd(2'd3, v); check("R11 status page arm", v, 8'h02);
        wr(2'd0, 8'h55);
        check("R2 page req", page_erase_req, 1);
        check("R2 busy", busy, 1);
        check("R2 page num", erase_page, 5);
        @(negedge clk);
        check("R9 single cycle", {page_erase_req, mass_erase_req}, 0);
        rd(2'd3, v); check("R6 arm used, R11 busy", v, 8'h01);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h12);
        dbg_en = 1'b1;
        wr(2'd0, 8'hAA);
        check("R8 mass ignored busy", mass_erase_req, 0);
        wr(2'd0, 8'h55);
        check("R8 page ignored busy", page_erase_req, 0);
        check("R9 page held", erase_page, 5);
        rd(2'd3, v); check("R10 stored arms", v, 8'h07);
        done_pulse();
        check("R12 busy falls", busy, 0);
        wr(2'd0, 8'h55);
        check("R10 page later", page_erase_req, 1);
        check("R10 page num", erase_page, 7'h12);
        done_pulse();
        wr(2'd0, 8'h55);
        check("R6 repeat ignored", {page_erase_req, busy}, 0);
        wr(2'd0, 8'hAA);
        check("R3 mass req", mass_erase_req, 1);
        check("R3 busy", busy, 1);
        done_pulse();
        check("R12 busy falls mass", busy, 0);
        dbg_en = 1'b0;
    endtask

    task automatic t_bad_keys();
        logic [7:0] v;
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h01);
        dbg_en = 1'b1;
        foreach (v[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [7:0] key;
            key = (k == 0) ? 8'h54 : (k == 1) ? 8'h00 : (k == 2) ? 8'hFF : 8'h56;
            wr(2'd0, key);
            check("R4 bad key no req", {page_erase_req, mass_erase_req, busy}, 0);
        end
        rd(2'd3, v); check("R4 arms kept", v, 8'h06);
        wr(2'd0, 8'h55);
        check("R2 page after bad keys", page_erase_req, 1);
        done_pulse();
        wr(2'd0, 8'hAA);
        check("R3 mass after bad keys", mass_erase_req, 1);
        done_pulse();
        dbg_en = 1'b0;
    endtask

    task automatic t_mass_guard();
        logic [7:0] v;
        wr(2'd0, 8'hAA);
        check("R7 no arm ignored", {mass_erase_req, busy}, 0);
        wr(2'd2, 8'h5A);
        wr(2'd0, 8'hAA);
        check("R7 no dbg ignored", {mass_erase_req, busy}, 0);
        rd(2'd3, v); check("R7 arm kept", v, 8'h04);
        dbg_en = 1'b1;
        wr(2'd0, 8'hAA);
        check("R7 accepted", mass_erase_req, 1);
        done_pulse();
        rd(2'd3, v); check("R7 arm used", v, 8'h00);
        wr(2'd0, 8'hAA);
        check("R7 repeat ignored", {mass_erase_req, busy}, 0);
        done_pulse();
        check("R12 done idle", {busy, page_erase_req, mass_erase_req}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page_flow();
        t_bad_keys();
        t_mass_guard();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule